// File: doc/BRIEF.md
# Satellite Tone Signalling Controller

This block drives the 22 kHz control tone that a satellite receiver uses to talk to outdoor equipment, and switches the supply for the low-noise block. Software loads up to eight message bytes, a tone divider and a control byte over a simple byte-wide register port. A single control byte chooses what happens next: an unbroken tone, a short burst in one of two positions, or a framed multi-byte message. Its start bit stays high while the line is in use and drops by itself once the transfer and its trailing silence are over.

The tone is built from a programmable divider on the fast system clock: one tone period is 32 divider ticks, so software programs the divider as the ceiling of the clock frequency over 32 times 22 kHz. Bits are pulse-width coded as periods of tone followed by silence, counted in whole tone periods. A receive path listens to a demodulated tone envelope, decodes the same pulse-width code, writes the reply bytes into the data registers and reports the byte count and an error flag.

Address map (byte registers): 0 control, 1 divider, 2 supply, 3 receive error, 4 to 11 data bytes 0 to 7. Control bits: 0 burst mode, 1 message mode, 2 burst position B, 3 start/busy, 6:4 byte count minus one, 7 receive enable. H below is the parameter HALF_BIT (tone periods per half bit cell).

Top module: `tone_sig_ctrl`

## Requirements
- R1: After reset tone_out, lnb_en and lnb_high are 0 and the control, divider, supply and receive-error registers read 0.
- R2: Supply register bit 1 drives lnb_en; lnb_high is supply bit 0 gated by bit 1, so it is never 1 while the supply is off.
- R3: A tone period lasts 32 × max(divider,1) clock cycles, tone_out high for the first half, and every accepted control write restarts the period at its first cycle.
- R4: Writing control with bit 3 and bit 1 set sends bytes from address 4 upward, count = bits 6:4 plus one, each MSB first followed by an odd-parity bit; a 0 is 2H periods of tone then H silent, a 1 is H of tone then 2H silent; the tone starts in the cycle after the write.
- R5: With bit 3 and bit 0 set and bit 2 clear, the block sends BURST_A periods of unbroken tone.
- R6: With bit 3, bit 0 and bit 2 set, the block sends nine logic-1 bit cells.
- R7: Every message or burst is followed by GUARD silent periods; control bit 3 reads 1 until the end of that silence and then clears itself, the other control bits unchanged.
- R8: Writes to the control register are ignored while a message, a burst or a reception is in progress.
- R9: Bit 3 with bits 1:0 both clear gives a continuous tone that does not self-clear; writing bit 3 to 0 stops it.
- R10: Writing bit 7 enables reception (bit 3 is then stored as 0); a tone pulse shorter than H + H/2 periods decodes as 1, longer as 0; each nine-bit group writes its byte to the next data register; after 4H silent periods bit 7 clears and bits 6:4 hold the byte count minus one.
- R11: The receive-error register reads 1 after a reception with a parity failure, a partial byte or more than eight bytes, and 0 after a clean one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr (combinational) |
| rx_env | input | 1 | Demodulated receive tone envelope |
| tone_out | output | 1 | Gated 22 kHz tone |
| lnb_en | output | 1 | Supply enable |
| lnb_high | output | 1 | High supply voltage select |

## Verification
The checker watches on every cycle that tone only appears while the start bit is set, that the pulse envelope exists only during a message or burst, that reception and transmission never hold the control byte at once, that the high-voltage select never stands without the supply, and that a transfer ends in silence. The bit coding, parity, byte order, burst lengths, guard length, ignored writes and receive decoding can only be shown by the bench's scenarios, which compare tone_out and the busy bit against a behavioural envelope model every clock and read back the receive results.

// File: rtl/tone_sig_pkg.sv
package tone_sig_pkg;
   localparam int ADDR_CTRL   = 0;
   localparam int ADDR_DIV    = 1;
   localparam int ADDR_SUPPLY = 2;
   localparam int ADDR_RXERR  = 3;
   localparam int ADDR_DATA0  = 4;
   localparam int TICKS_PER_PERIOD = 32;
   // the length field is three bits wide, which fixes the slot count
   localparam int MSG_SLOTS = 8;
   typedef enum logic [1:0] {TX_IDLE, TX_MARK, TX_SPACE, TX_GUARD} tx_state_e;
endpackage

// File: rtl/tone_sig_timebase.sv
module tone_sig_timebase
   import tone_sig_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             phase_hi,
   output logic             period_end
);
   localparam int SUB_W = $clog2(TICKS_PER_PERIOD);

   logic [DIV_W-1:0] pcnt;
   logic [DIV_W-1:0] lim;
   logic [SUB_W-1:0] sub;
   logic             tick;

   assign lim        = (div == '0) ? '0 : div - 1'b1;
   assign tick       = (pcnt >= lim);
   assign phase_hi   = ~sub[SUB_W-1];
   assign period_end = tick & (&sub);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         sub  <= '0;
      end else if (restart) begin
         pcnt <= '0;
         sub  <= '0;
      end else if (tick) begin
         pcnt <= '0;
         sub  <= sub + 1'b1;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/tone_sig_tx.sv
module tone_sig_tx
   import tone_sig_pkg::*;
#(
   parameter int HALF_BIT = 11,
   parameter int BURST_A  = 275,
   parameter int GUARD    = 330,
   parameter int SEG_W    = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       msg_mode,
   input  logic       burst_b,
   input  logic [2:0] last_idx,
   input  logic [7:0] data [MSG_SLOTS],
   input  logic       period_end,
   output logic       env,
   output logic       done
);
   localparam logic [SEG_W-1:0] L_H  = SEG_W'(HALF_BIT);
   localparam logic [SEG_W-1:0] L_2H = SEG_W'(2 * HALF_BIT);
   localparam logic [SEG_W-1:0] L_A  = SEG_W'(BURST_A);
   localparam logic [SEG_W-1:0] L_G  = SEG_W'(GUARD);

   tx_state_e        st;
   logic [SEG_W-1:0] seg;
   logic [2:0]       byte_i, last_q, nxt_byte;
   logic [3:0]       bit_i, nxt_pos;
   logic             msg_q, bb_q;
   logic             cur_bit, nxt_bit, go_bit, seg_end;

   function automatic logic bit_of(input logic [7:0] b, input logic [3:0] pos);
      logic [3:0] pm1;
      pm1 = pos - 4'd1;
      if (pos == 4'd0) return ~^b;
      return b[pm1[2:0]];
   endfunction

   assign cur_bit  = bb_q | bit_of(data[byte_i], bit_i);
   assign nxt_byte = (bit_i == 4'd0) ? byte_i + 3'd1 : byte_i;
   assign nxt_pos  = (bit_i == 4'd0) ? 4'd8 : bit_i - 4'd1;
   assign nxt_bit  = bb_q | bit_of(data[nxt_byte], nxt_pos);
   assign go_bit   = burst_b | data[0][7];
   assign seg_end  = period_end & (seg == SEG_W'(1));
   assign env      = (st == TX_MARK);
   assign done     = (st == TX_GUARD) & seg_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= TX_IDLE; seg <= '0; byte_i <= '0; bit_i <= '0;
         last_q <= '0; msg_q <= 1'b0; bb_q <= 1'b0;
      end else if (go) begin
         st     <= TX_MARK;
         byte_i <= '0;
         bit_i  <= 4'd8;
         last_q <= msg_mode ? last_idx : 3'd0;
         msg_q  <= msg_mode;
         bb_q   <= burst_b;
         seg    <= (msg_mode | burst_b) ? (go_bit ? L_H : L_2H) : L_A;
      end else if (st != TX_IDLE && period_end) begin
         if (!seg_end) begin
            seg <= seg - 1'b1;
         end else begin
            unique case (st)
               TX_MARK: begin
                  if (!msg_q && !bb_q) begin
                     st <= TX_GUARD; seg <= L_G;
                  end else begin
                     st <= TX_SPACE; seg <= cur_bit ? L_2H : L_H;
                  end
               end
               TX_SPACE: begin
                  if (bit_i != 4'd0 || byte_i != last_q) begin
                     st <= TX_MARK; byte_i <= nxt_byte; bit_i <= nxt_pos;
                     seg <= nxt_bit ? L_H : L_2H;
                  end else begin
                     st <= TX_GUARD; seg <= L_G;
                  end
               end
               default: st <= TX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/tone_sig_rx.sv
module tone_sig_rx
   import tone_sig_pkg::*;
#(
   parameter int HALF_BIT = 11,
   parameter int SEG_W    = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       active,
   input  logic       env_in,
   input  logic       period_end,
   output logic       wr_en,
   output logic [2:0] wr_idx,
   output logic [7:0] wr_byte,
   output logic       fin,
   output logic [2:0] fin_cnt,
   output logic       fin_err
);
   localparam logic [SEG_W-1:0] THR   = SEG_W'(HALF_BIT + HALF_BIT / 2);
   localparam logic [SEG_W-1:0] END_S = SEG_W'(4 * HALF_BIT - 1);
   localparam logic [3:0]       OVER  = 4'(MSG_SLOTS + 1);

   logic             env_s, env_p, got, err;
   logic [SEG_W-1:0] mcnt, scnt;
   logic [7:0]       shreg;
   logic [3:0]       bitc, nbytes;
   logic [8:0]       full;
   logic             rise, fall, byte_done;

   assign rise      = env_s & ~env_p;
   assign fall      = env_p & ~env_s;
   assign full      = {shreg, (mcnt < THR)};
   assign byte_done = active & fall & (bitc == 4'd8);
   assign wr_en     = byte_done & (nbytes < 4'(MSG_SLOTS));
   assign wr_idx    = nbytes[2:0];
   assign wr_byte   = full[8:1];
   assign fin       = active & got & ~env_s & ~env_p & period_end & (scnt == END_S);
   assign fin_cnt   = nbytes[2:0] - 3'd1;
   assign fin_err   = err | (bitc != 4'd0) | (nbytes == 4'd0) | (nbytes > 4'(MSG_SLOTS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         env_s <= 1'b0; env_p <= 1'b0; got <= 1'b0; err <= 1'b0;
         mcnt <= '0; scnt <= '0; shreg <= '0; bitc <= '0; nbytes <= '0;
      end else if (go) begin
         env_s <= 1'b0; env_p <= 1'b0; got <= 1'b0; err <= 1'b0;
         mcnt <= '0; scnt <= '0; shreg <= '0; bitc <= '0; nbytes <= '0;
      end else if (active) begin
         env_s <= env_in;
         env_p <= env_s;
         if (rise) begin
            mcnt <= '0;
         end else if (env_s && period_end && !(&mcnt)) begin
            mcnt <= mcnt + 1'b1;
         end
         if (fall) begin
            scnt  <= '0;
            got   <= 1'b1;
            shreg <= full[7:0];
            if (bitc == 4'd8) begin
               bitc <= '0;
               if (nbytes != OVER) nbytes <= nbytes + 4'd1;
               if (!(^full)) err <= 1'b1;
            end else begin
               bitc <= bitc + 4'd1;
            end
         end else if (!env_s && got && period_end && !(&scnt)) begin
            scnt <= scnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tone_sig_ctrl.sv
module tone_sig_ctrl
   import tone_sig_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int HALF_BIT = 11,
   parameter int BURST_A  = 275,
   parameter int GUARD    = 330,
   parameter int AW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rd_data,
   input  logic          rx_env,
   output logic          tone_out,
   output logic          lnb_en,
   output logic          lnb_high
);
   localparam int SEG_MAX0 = (BURST_A > GUARD) ? BURST_A : GUARD;
   localparam int SEG_MAX  = (SEG_MAX0 > 4 * HALF_BIT) ? SEG_MAX0 : 4 * HALF_BIT;
   localparam int SEG_W    = $clog2(SEG_MAX + 1);

   generate
      if (AW < 4)       begin : g_bad_aw   $error("AW too small for the register map"); end
      if (HALF_BIT < 2) begin : g_bad_half $error("HALF_BIT must be at least 2"); end
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div $error("DIV_W must be 1 to 8"); end
      if (BURST_A < 1 || GUARD < 1) begin : g_bad_len $error("burst and guard must be non-zero"); end
   endgenerate

   logic [7:0]       ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic [1:0]       sup_q;
   logic             rxerr_q;
   logic [7:0]       data_q [MSG_SLOTS];

   logic ctrl_acc, locked, tx_go, rx_go, cont_on;
   logic phase_hi, period_end, tx_env, tx_done;
   logic rx_wr, rx_fin, rx_err;
   logic [2:0] rx_idx, rx_cnt;
   logic [7:0] rx_byte;

   assign locked   = (ctrl_q[3] & (ctrl_q[1] | ctrl_q[0])) | ctrl_q[7];
   assign ctrl_acc = wr_en & (addr == AW'(ADDR_CTRL)) & ~locked;
   assign tx_go    = ctrl_acc & wdata[3] & (wdata[1] | wdata[0]) & ~wdata[7];
   assign rx_go    = ctrl_acc & wdata[7];
   assign cont_on  = ctrl_q[3] & ~ctrl_q[1] & ~ctrl_q[0];
   assign tone_out = (tx_env | cont_on) & phase_hi;
   assign lnb_en   = sup_q[1];
   assign lnb_high = sup_q[1] & sup_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; div_q <= '0; sup_q <= '0; rxerr_q <= 1'b0;
      end else begin
         if (ctrl_acc) begin
            ctrl_q <= {wdata[7:4], wdata[3] & ~wdata[7], wdata[2:0]};
         end else if (tx_done) begin
            ctrl_q[3] <= 1'b0;
         end else if (rx_fin) begin
            ctrl_q[7]   <= 1'b0;
            ctrl_q[6:4] <= rx_cnt;
         end
         if (wr_en && addr == AW'(ADDR_DIV))    div_q <= wdata[DIV_W-1:0];
         if (wr_en && addr == AW'(ADDR_SUPPLY)) sup_q <= wdata[1:0];
         if (rx_go)       rxerr_q <= 1'b0;
         else if (rx_fin) rxerr_q <= rx_err;
      end
   end

   for (genvar i = 0; i < MSG_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   data_q[i] <= '0;
         else if (wr_en && addr == AW'(ADDR_DATA0 + i)) data_q[i] <= wdata;
         else if (rx_wr && rx_idx == 3'(i))             data_q[i] <= rx_byte;
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == AW'(ADDR_CTRL))        rd_data = ctrl_q;
      else if (addr == AW'(ADDR_DIV))    rd_data = 8'(div_q);
      else if (addr == AW'(ADDR_SUPPLY)) rd_data = {6'd0, sup_q};
      else if (addr == AW'(ADDR_RXERR))  rd_data = {7'd0, rxerr_q};
      else begin
         for (int i = 0; i < MSG_SLOTS; i++)
            if (addr == AW'(ADDR_DATA0 + i)) rd_data = data_q[i];
      end
   end

   tone_sig_timebase #(.DIV_W(DIV_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_acc), .div(div_q),
      .phase_hi(phase_hi), .period_end(period_end)
   );

   tone_sig_tx #(.HALF_BIT(HALF_BIT), .BURST_A(BURST_A), .GUARD(GUARD), .SEG_W(SEG_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .go(tx_go), .msg_mode(wdata[1]),
      .burst_b(wdata[2] & ~wdata[1]), .last_idx(wdata[6:4]), .data(data_q),
      .period_end(period_end), .env(tx_env), .done(tx_done)
   );

   tone_sig_rx #(.HALF_BIT(HALF_BIT), .SEG_W(SEG_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .go(rx_go), .active(ctrl_q[7]), .env_in(rx_env),
      .period_end(period_end), .wr_en(rx_wr), .wr_idx(rx_idx), .wr_byte(rx_byte),
      .fin(rx_fin), .fin_cnt(rx_cnt), .fin_err(rx_err)
   );
endmodule

// File: rtl/tone_sig_ctrl_chk.sv
module tone_sig_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tone_out,
   input logic       lnb_en,
   input logic       lnb_high,
   input logic [7:0] ctrl,
   input logic       tx_env
);
   // R3 R9: tone only while the start bit is held
   assert_tone_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tone_out |-> ctrl[3]);

   // R2: high voltage only with supply on
   assert_high_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lnb_high |-> lnb_en);

   // R4 R5 R6: pulse envelope only during a message or burst
   assert_env_in_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_env |-> (ctrl[3] && (ctrl[1] || ctrl[0])));

   // R10: reception and transmission never share the control byte
   assert_no_rx_tx_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl[7] && ctrl[3]));

   // R7: a message or burst ends in silence
   assert_silent_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl[3]) && $past(ctrl[1] || ctrl[0])) |-> !$past(tone_out));
endmodule

bind tone_sig_ctrl tone_sig_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tone_out(tone_out), .lnb_en(lnb_en),
   .lnb_high(lnb_high), .ctrl(ctrl_q), .tx_env(tx_env)
);

// File: tb/tone_sig_ctrl_bench.sv
module tone_sig_ctrl_bench;
   localparam int H  = 4;
   localparam int BA = 10;
   localparam int G  = 6;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rd_data;
   logic          rx_env = 1'b0;
   logic          tone_out, lnb_en, lnb_high;

   int n_chk = 0;
   int n_err = 0;
   bit exp_env[$];

   always #5 clk = ~clk;

   tone_sig_ctrl #(.DIV_W(8), .HALF_BIT(H), .BURST_A(BA), .GUARD(G), .AW(AW)) u_tone_sig_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rd_data(rd_data), .rx_env(rx_env), .tone_out(tone_out),
      .lnb_en(lnb_en), .lnb_high(lnb_high)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic wr(input int a, input logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = v;
      @(negedge clk); wr_en = 1'b0; addr = '0;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      @(negedge clk); addr = AW'(a); #1; v = rd_data;
   endtask

   function automatic void push_bit(input bit b);
      for (int i = 0; i < (b ? H : 2 * H); i++) exp_env.push_back(1'b1);
      for (int i = 0; i < (b ? 2 * H : H); i++) exp_env.push_back(1'b0);
   endfunction

   function automatic void push_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) push_bit(b[i]);
      push_bit(~^b);
   endfunction

   // drives the control write, then compares tone_out and busy every clock
   task automatic run_tx(input int d, input logic [7:0] cv, input int inj_t,
                         input logic [7:0] inj_v, input string tag);
      int p, cpp, terr, berr;
      bit et, eb;
      for (int i = 0; i < G; i++) exp_env.push_back(1'b0);
      p = exp_env.size(); cpp = 32 * d; terr = 0; berr = 0;
      @(negedge clk); wr_en = 1'b1; addr = '0; wdata = cv;
      for (int t = 0; t < p * cpp + 4; t++) begin
         @(negedge clk);
         wr_en = (t == inj_t); addr = '0; wdata = inj_v;
         #1;
         eb = (t < p * cpp);
         et = eb && exp_env[t / cpp] && ((t % cpp) < cpp / 2);
         if (tone_out !== et) terr++;
         if (rd_data[3] !== eb) berr++;
      end
      wr_en = 1'b0;
      check(terr == 0, {tag, " tone envelope mismatching cycles"}, terr, 0);
      check(berr == 0, "R7 busy bit mismatching cycles", berr, 0);
      exp_env.delete();
   endtask

   task automatic rx_byte(input logic [7:0] b, input bit bad);
      logic [8:0] f;
      f = {b, (~^b) ^ bad};
      for (int i = 8; i >= 0; i--) begin
         @(negedge clk); rx_env = 1'b1;
         repeat ((f[i] ? H : 2 * H) * 32 - 1) @(negedge clk);
         @(negedge clk); rx_env = 1'b0;
         repeat ((f[i] ? 2 * H : H) * 32 - 1) @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(tone_out === 1'b0 && lnb_en === 1'b0 && lnb_high === 1'b0, "R1 outputs",
            {tone_out, lnb_en, lnb_high}, 0);
      rd(0, v); check(v === 8'h00, "R1 control", v, 0);
      rd(1, v); check(v === 8'h00, "R1 divider", v, 0);
      rd(3, v); check(v === 8'h00, "R1 rx error", v, 0);

      // R2 supply control
      wr(2, 8'h03); check(lnb_en === 1'b1 && lnb_high === 1'b1, "R2 on high", {lnb_en, lnb_high}, 3);
      wr(2, 8'h01); check(lnb_en === 1'b0 && lnb_high === 1'b0, "R2 off", {lnb_en, lnb_high}, 0);
      wr(2, 8'h02); check(lnb_en === 1'b1 && lnb_high === 1'b0, "R2 on low", {lnb_en, lnb_high}, 2);

      // R3 divider readback, R4 two-byte message at divider 1
      wr(1, 8'h01); rd(1, v); check(v === 8'h01, "R3 divider readback", v, 1);
      wr(4, 8'hA5); wr(5, 8'h3C);
      push_byte(8'hA5); push_byte(8'h3C);
      run_tx(1, 8'h1A, -1, 8'h00, "R4 R3 two bytes div1");
      rd(0, v); check(v === 8'h12, "R7 other control bits kept", v, 8'h12);

      // R6 burst B with an ignored control write in the middle (R8)
      for (int i = 0; i < 9; i++) push_bit(1'b1);
      run_tx(1, 8'h0D, 100, 8'h00, "R6 R8 burst B");

      // R5 burst A at divider 2
      wr(1, 8'h02);
      for (int i = 0; i < BA; i++) exp_env.push_back(1'b1);
      run_tx(2, 8'h09, -1, 8'h00, "R5 burst A div2");

      // R4 eight-byte message, includes all-zero and all-one bytes
      for (int i = 0; i < 8; i++) begin
         v = (i == 0) ? 8'h00 : (i == 7) ? 8'hFF : 8'((i * 37 + 11) & 8'hFF);
         wr(4 + i, v); push_byte(v);
      end
      run_tx(2, 8'h7A, -1, 8'h00, "R4 eight bytes div2");

      // R9 continuous tone
      wr(1, 8'h01);
      begin
         int cerr;
         cerr = 0;
         @(negedge clk); wr_en = 1'b1; addr = '0; wdata = 8'h08;
         for (int t = 0; t < 200; t++) begin
            @(negedge clk); wr_en = 1'b0; #1;
            if (tone_out !== ((t % 32) < 16) || rd_data[3] !== 1'b1) cerr++;
         end
         check(cerr == 0, "R9 continuous tone cycles", cerr, 0);
      end
      wr(0, 8'h00);
      repeat (40) begin
         @(negedge clk);
         if (tone_out !== 1'b0) v = 8'hEE;
      end
      check(v !== 8'hEE, "R9 tone stopped", tone_out, 0);

      // R10 reception of two clean bytes, with R8 write ignored while listening
      wr(0, 8'h80);
      wr(0, 8'h0A);
      rd(0, v); check(v === 8'h80 && tone_out === 1'b0, "R8 write ignored during rx", v, 8'h80);
      rx_byte(8'h5A, 1'b0); rx_byte(8'h81, 1'b0);
      repeat (24 * 32) @(negedge clk);
      rd(0, v); check(v === 8'h10, "R10 control after reply", v, 8'h10);
      rd(4, v); check(v === 8'h5A, "R10 first reply byte", v, 8'h5A);
      rd(5, v); check(v === 8'h81, "R10 second reply byte", v, 8'h81);
      rd(3, v); check(v === 8'h00, "R11 clean reply", v, 0);

      // R11 reply with a parity error
      wr(0, 8'h80);
      rx_byte(8'h33, 1'b1);
      repeat (24 * 32) @(negedge clk);
      rd(3, v); check(v === 8'h01, "R11 parity error flagged", v, 1);
      rd(0, v); check(v[7] === 1'b0, "R10 receive enable cleared", v, 0);

      summary();
   end
endmodule